// File: doc/BRIEF.md
# Serial Sampling Converter Frame Controller

This block sits on the host side of a three-wire sampling converter and runs its conversion frames. A rising edge on the convert strobe ends the converter's acquisition and starts a conversion. The controller then runs a fixed number of serial clock periods. It captures the status bit and the twelve result bits on rising serial clock edges, and the trailing clocks of the frame give the converter its acquisition window before the next convert edge.

Each finished frame yields one result word on a valid/ready output. A mode input, latched when the frame starts, chooses how the raw code is read: straight binary for a unipolar input range, or two's complement for a bipolar range. A qualifier bit goes with every result. It is high only when the converter reported its reference as settled and no wake request arrived while that frame was running. Frames keep running while the reference settles, but their results are marked untrusted.

The serial clock is the system clock divided by the even parameter `CLK_DIV`. The frame length in serial clock periods is set by `FRAME_SCLKS`, which must be at least the capture count plus three.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, `conv_o`, `sclk_o` and `res_valid` are low. No convert edge appears while `enable` is low.
- R2: Each frame has exactly `FRAME_SCLKS` rising edges on `sclk_o`. The serial clock period is `CLK_DIV` system clocks and the duty cycle is 50%.
- R3: `conv_o` rises while `sclk_o` is low. The first rising edge of `sclk_o` follows `CLK_DIV/2` system clocks later.
- R4: `conv_o` stays high for exactly `CLK_DIV` system clocks. Two convert rises are at least `FRAME_SCLKS*CLK_DIV` system clocks apart.
- R5: `sdata_in` is sampled on the system clock edge where `sclk_o` goes high, on the first `DATA_W+1` rising edges of a frame only. The first captured bit is the reference-ready status. The data bits follow, most significant bit first. Bits after these have no effect on the result.
- R6: With `bipolar` low, `res_data` equals the raw code. With `bipolar` high, `res_data` is the raw code with its top bit inverted. The mode used is the value of `bipolar` when the convert strobe rises.
- R7: `res_refok` equals the captured status bit. It is forced low when `wake_req` is high at any clock from the frame's convert edge through its completion.
- R8: `res_valid` rises once the frame's last serial clock has fallen. The result holds stable until `res_ready` is seen, and no new frame starts while `res_valid` is high.
- R9: A new frame starts only while `enable` is high. Lowering `enable` mid-frame lets the current frame finish and deliver its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new frames to start |
| wake_req | input | 1 | Wake request; marks the current frame's result untrusted |
| bipolar | input | 1 | 1: two's complement result, 0: straight binary |
| sdata_in | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | DATA_W | Formatted conversion result |
| res_refok | output | 1 | Result trusted: reference ready and no wake in the frame |

## Verification
The bench models the converter. It changes its data line after each falling serial clock, and it drives ones after the captured bits, so a design that shifts one bit too many or samples on the wrong edge returns a shifted or corrupted word. Codes on both sides of the bipolar zero crossing, the extremes of each range, and a mode flip in the middle of a frame catch a wrong sign conversion and a mode that is not latched at the convert edge. A wake pulse inside a frame whose status bit reads ready shows whether the qualifier really drops. A stalled consumer, a mid-frame disable and back-to-back frames expose a controller that overwrites a pending result, abandons a running frame, or shortens the acquisition window or the convert-to-clock setup.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;
  // frame sequencer activity
  typedef enum logic {
    FC_IDLE = 1'b0,
    FC_RUN  = 1'b1
  } fc_state_e;

  // offset-binary to two's complement: flip the top bit when asked
  function automatic logic flip_top(input logic top_bit, input logic signed_mode);
    return top_bit ^ signed_mode;
  endfunction
endpackage

// File: rtl/adc_fc_tick.sv
module adc_fc_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || tick_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CW'(HALF - 1));
endmodule

// File: rtl/adc_fc_seq.sv
module adc_fc_seq
  import adc_fc_pkg::*;
#(
  parameter int HALF        = 2,
  parameter int FRAME_SCLKS = 16,
  parameter int CAP_BITS    = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_ok,
  output logic start_o,
  output logic cap_o,
  output logic done_o,
  output logic conv_o,
  output logic sclk_o
);
  localparam int HW  = $clog2(2 * FRAME_SCLKS + 1);
  localparam int CDW = $clog2(2 * HALF + 1);

  fc_state_e     st_q;
  logic [HW-1:0] half_q;
  logic [HW-1:0] half_nxt;
  logic          conv_q;
  logic          sclk_q;
  logic          adv;

  always_comb begin
    half_nxt = half_q + 1'b1;
    adv      = tick && (st_q == FC_RUN);
    start_o  = tick && (st_q == FC_IDLE) && start_ok;
    cap_o    = adv && half_nxt[0] && (half_nxt <= HW'(2 * CAP_BITS - 1));
    done_o   = adv && (half_nxt == HW'(2 * FRAME_SCLKS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FC_IDLE;
      half_q <= '0;
      conv_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (start_o) begin
      st_q   <= FC_RUN;
      half_q <= '0;
      conv_q <= 1'b1;
      sclk_q <= 1'b0;
    end else if (adv) begin
      half_q <= half_nxt;
      sclk_q <= half_nxt[0];
      conv_q <= (half_nxt < HW'(2));
      if (done_o) st_q <= FC_IDLE;
    end
  end

  assign conv_o = conv_q;
  assign sclk_o = sclk_q;

  // checker state: serial clock rises per frame, convert high time
  logic           sclk_d;
  logic [HW-1:0]  rises_q;
  logic [CDW-1:0] conv_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      rises_q   <= '0;
      conv_hi_q <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (start_o)                rises_q <= '0;
      else if (sclk_q && !sclk_d) rises_q <= rises_q + 1'b1;
      if (conv_q) conv_hi_q <= conv_hi_q + 1'b1;
      else        conv_hi_q <= '0;
    end
  end

  AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (rst)
    $fell(st_q == FC_RUN) |-> rises_q == HW'(FRAME_SCLKS)) else $error("frame edge count"); // R2
  AST_CONV_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_q) |-> !sclk_q) else $error("convert rose with clock high"); // R3
  AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_q) |-> conv_hi_q == CDW'(2 * HALF)) else $error("convert width"); // R4
endmodule

// File: rtl/adc_fc_shift.sv
module adc_fc_shift #(
  parameter int CAP_BITS = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                cap,
  input  logic                sdin,
  output logic [CAP_BITS-1:0] word_o
);
  localparam int NW = $clog2(CAP_BITS + 1);

  logic [CAP_BITS-1:0] sh_q;
  logic [NW-1:0]       n_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (cap) begin
      sh_q <= {sh_q[CAP_BITS-2:0], sdin};
      n_q  <= n_q + 1'b1;
    end
  end

  assign word_o = sh_q;

  AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cap |-> n_q < NW'(CAP_BITS)) else $error("too many captures"); // R5
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_fc_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int FRAME_SCLKS = 16,
  parameter int DATA_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wake_req,
  input  logic              bipolar,
  input  logic              sdata_in,
  output logic              conv_o,
  output logic              sclk_o,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_refok
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int CAP_BITS = DATA_W + 1;

  logic                tick;
  logic                start;
  logic                cap;
  logic                done;
  logic [CAP_BITS-1:0] word;
  logic                mode_q;
  logic                wake_seen_q;
  logic [DATA_W-1:0]   fmt;

  adc_fc_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  adc_fc_seq #(.HALF(HALF), .FRAME_SCLKS(FRAME_SCLKS), .CAP_BITS(CAP_BITS)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .start_ok(enable && !res_valid),
    .start_o(start), .cap_o(cap), .done_o(done), .conv_o(conv_o), .sclk_o(sclk_o)
  );

  adc_fc_shift #(.CAP_BITS(CAP_BITS)) u_shift (
    .clk(clk), .rst(rst), .clr(start), .cap(cap), .sdin(sdata_in), .word_o(word)
  );

  always_comb begin
    fmt         = word[DATA_W-1:0];
    fmt[DATA_W-1] = flip_top(word[DATA_W-1], mode_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= 1'b0;
      wake_seen_q <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_refok   <= 1'b0;
    end else begin
      if (start) begin
        mode_q      <= bipolar;
        wake_seen_q <= wake_req;
      end else if (wake_req) begin
        wake_seen_q <= 1'b1;
      end
      if (done) begin
        res_valid <= 1'b1;
        res_data  <= fmt;
        res_refok <= word[CAP_BITS-1] && !(wake_seen_q || wake_req);
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_refok)) else $error("result not held"); // R8
  AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_o) |-> !$past(res_valid)) else $error("frame started over pending result"); // R8
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_o) |-> $past(enable)) else $error("frame started while disabled"); // R9
endmodule

// File: tb/adc_frame_ctrl_bench.sv
`timescale 1ns/1ps
module adc_frame_ctrl_bench;
  localparam int CLK_DIV = 4;
  localparam int FRAMES  = 16;
  localparam int DW      = 12;
  localparam int NV      = 8;
  // {bipolar, ref bit, wake, raw code, expected ok, expected data}
  localparam logic [39:0] VEC [NV] = '{
    40'h0_1_0_ABC_1_ABC, 40'h1_1_0_800_1_000, 40'h1_1_0_7FF_1_FFF, 40'h0_0_0_5A5_0_5A5,
    40'h0_1_1_FFF_0_FFF, 40'h1_1_0_000_1_800, 40'h0_1_0_001_1_001, 40'h1_0_0_123_0_923};

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, wake_req = 1'b0, bipolar = 1'b0;
  logic res_ready = 1'b0, sdata, conv_o, sclk_o, res_valid, res_refok;
  logic [DW-1:0] res_data;
  logic [DW:0] dev_word = '0;
  int dev_idx = 0, n_vec = 0, n_bad = 0, cyc = 0;
  int t_conv = 0, t_first = 0, t_rise = 0, rises = 0, conv_hi = 0, starts = 0;
  int min_gap = 1000000, period_bad = 0;
  logic pc = 1'b0, ps = 1'b0, fin = 1'b0;

  always #5 clk = ~clk;

  adc_frame_ctrl #(.CLK_DIV(CLK_DIV), .FRAME_SCLKS(FRAMES), .DATA_W(DW)) u_adc_frame_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .wake_req(wake_req), .bipolar(bipolar),
    .sdata_in(sdata), .conv_o(conv_o), .sclk_o(sclk_o), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_refok(res_refok));

  // converter model: status bit first, data MSB first, ones afterwards
  assign sdata = (dev_idx < DW + 1) ? dev_word[DW - dev_idx] : 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (conv_o && !pc) begin
      if (starts > 0 && cyc - t_conv < min_gap) min_gap = cyc - t_conv;
      t_conv = cyc; rises = 0; conv_hi = 0; dev_idx = 0; starts++;
    end
    if (conv_o) conv_hi++;
    if (sclk_o && !ps) begin
      rises++;
      if (rises == 1) t_first = cyc;
      else if (cyc - t_rise != CLK_DIV) period_bad++;
      t_rise = cyc;
    end
    if (!sclk_o && ps) dev_idx++;
    pc = conv_o; ps = sclk_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 3000 && !res_valid; i++) @(negedge clk);
    chk("R8 result delivered", int'(res_valid), 1);
  endtask

  task automatic accept();
    @(negedge clk); res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int s0;
    logic [DW-1:0] d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 conv low", int'(conv_o), 0);
    chk("R1 sclk low", int'(sclk_o), 0);
    chk("R1 valid low", int'(res_valid), 0);
    chk("R1 R9 no frame while disabled", starts, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bipolar  = VEC[i][36];
      dev_word = {VEC[i][32], VEC[i][27:16]};
      if (i == 0) enable = 1'b1;
      else accept();
      if (VEC[i][28]) begin
        @(posedge conv_o); @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
      end
      wait_valid();
      chk("R5 R6 data", int'(res_data), int'(VEC[i][11:0]));
      chk("R7 ref qualifier", int'(res_refok), int'(VEC[i][12]));
      chk("R2 rises per frame", rises, FRAMES);
      chk("R3 convert lead", t_first - t_conv, CLK_DIV / 2);
      chk("R4 convert width", conv_hi, CLK_DIV);
    end

    // R8: stalled consumer keeps the result and blocks new frames
    d0 = res_data; s0 = starts;
    repeat (8) @(negedge clk);
    chk("R8 valid held", int'(res_valid), 1);
    chk("R8 data held", int'(res_data), int'(d0));
    chk("R8 no frame while pending", starts, s0);

    // R6: mode change mid-frame is ignored
    bipolar = 1'b1; dev_word = {1'b1, 12'h800};
    accept();
    @(posedge conv_o); @(negedge clk); bipolar = 1'b0;
    wait_valid();
    chk("R6 mode latched at convert", int'(res_data), 12'h000);

    // R9: disable mid-frame, frame still completes
    dev_word = {1'b1, 12'h3C3};
    accept();
    @(posedge conv_o); @(negedge clk); enable = 1'b0;
    wait_valid();
    chk("R9 frame finished after disable", int'(res_data), 12'h3C3);
    accept();
    s0 = starts;
    repeat (200) @(negedge clk);
    chk("R9 no frame after disable", starts, s0);

    // R4 R2: back-to-back frames
    res_ready = 1'b1; enable = 1'b1; s0 = starts;
    for (int i = 0; i < 2000 && starts < s0 + 5; i++) @(negedge clk);
    chk("R4 frames continue", int'(starts >= s0 + 5), 1);
    chk("R4 min convert spacing", int'(min_gap >= FRAMES * CLK_DIV), 1);
    chk("R2 clock period", period_bad, 0);
    res_ready = 1'b0; enable = 1'b0;

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule